// File: doc/BRIEF.md
# Rate-Adaptive Packet Framer

This block sits between a byte-oriented serial port and a pair of isochronous bus endpoints. Inbound, serial bytes collect in a receive FIFO. On every packet-start strobe the block sends one 37-byte packet toward the bus. The first byte carries the number of payload bytes that follow. The payload bytes come next in arrival order, and zero bytes pad the packet to its full length. The payload size is nominally 32. It moves to 36 or 28 according to how full the receive FIFO is. This lets the host track the drift between the serial clock and the bus clock.

Outbound, the block takes 37-byte packets of the same layout from the bus side. It reads the leading count byte, forwards exactly that many payload bytes into a transmit FIFO and discards the padding. The serial port then drains that FIFO. Sticky flags report an overrun of the receive FIFO, a packet that could not be filled, a serial pull from an empty transmit FIFO and an illegal outbound count. Reset is the only way to clear them.

Top module: `rate_framer`

## Requirements
- R1: Every inbound packet is exactly 37 byte transfers on the endpoint side, with `ep_in_sop` high on the first transfer only. Bytes are offered only after a `frame_start` strobe. While a transfer is stalled by `ep_in_ready` low, `ep_in_valid` and `ep_in_data` stay stable.
- R2: Inbound byte 0 is the payload count, and its value is always one of 28, 32, 36 or 0.
- R3: The count is selected from the receive FIFO level in the cycle that `frame_start` is accepted. A level above HI_TH (default 40) selects 36. A level below LO_TH (default 24) selects 28. Any other level selects 32.
- R4: If the FIFO holds fewer bytes than the selected count, the count drops to the largest of 36, 32 or 28 that the level covers, or to 0 if the level is below 28. `rx_underflow` then sets and stays set until reset.
- R5: Inbound bytes 1..count are the received serial bytes in arrival order. Every byte after them is 0x00.
- R6: A `frame_start` strobe that arrives while a packet is in progress is ignored, so no second packet follows.
- R7: Outbound, byte 0 of each 37-byte packet is a count. Only bytes 1..count reach `ser_out_data`, in order. The count byte and the padding are dropped.
- R8: An outbound count other than 28, 32 or 36 is handled as 32 and sets the sticky `count_err`.
- R9: `ser_in_ready` is low while the 64-byte receive FIFO is full. A serial byte offered then is dropped without disturbing stored data, and `rx_overflow` sets and stays set.
- R10: `tx_underflow` sets and stays set when `ser_out_ready` is high while the transmit FIFO is empty. This applies only after at least one byte has entered that FIFO.
- R11: After reset, all four flags are low, `ep_in_valid` and `ser_out_valid` are low and `ser_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Packet-start strobe for the inbound packer |
| ser_in_data | input | 8 | Received serial byte |
| ser_in_valid | input | 1 | Received byte present |
| ser_in_ready | output | 1 | Receive FIFO has room |
| ep_in_data | output | 8 | Inbound packet byte toward the bus endpoint |
| ep_in_valid | output | 1 | Inbound packet byte present |
| ep_in_ready | input | 1 | Endpoint accepts the inbound byte |
| ep_in_sop | output | 1 | Current inbound byte is the count byte |
| ep_out_data | input | 8 | Outbound packet byte from the bus endpoint |
| ep_out_valid | input | 1 | Outbound packet byte present |
| ep_out_ready | output | 1 | Block accepts the outbound byte |
| ser_out_data | output | 8 | Byte for the serial transmitter |
| ser_out_valid | output | 1 | Transmit FIFO holds a byte |
| ser_out_ready | input | 1 | Serial transmitter takes a byte |
| rx_overflow | output | 1 | Sticky: serial byte offered to a full receive FIFO |
| rx_underflow | output | 1 | Sticky: an inbound count was reduced for lack of data |
| tx_underflow | output | 1 | Sticky: serial pull from an empty transmit FIFO |
| count_err | output | 1 | Sticky: illegal outbound count seen |

## Verification
A corrupted receive FIFO level shows up in the count byte of the very next packet. The count would move to the wrong band or be reduced for no reason, and `rx_underflow` would turn on with it. A slipped position counter in the packer would either stretch or shorten the packet, which is visible within 37 transfers. It would also shift the payload against the zero padding, or raise `ep_in_sop` on the wrong byte. On the outbound side, a wrong latched count changes how many bytes drain from the serial output after that single packet. A misread count byte shows at once in `count_err`, one cycle after the byte.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int PKT_LEN = 37;

    typedef logic [7:0] byte_t;
    typedef logic [5:0] pos_t;

    localparam pos_t  LAST_POS = 6'(PKT_LEN - 1);
    localparam byte_t CNT_SLOW = 8'd28;
    localparam byte_t CNT_NOM  = 8'd32;
    localparam byte_t CNT_FAST = 8'd36;
    localparam byte_t PAD_BYTE = 8'h00;

    typedef enum logic [1:0] {
        RATE_SLOW,
        RATE_NOM,
        RATE_FAST
    } rate_e;

    typedef struct packed {
        byte_t data;
        logic  sop;
    } beat_t;

    function automatic byte_t rate_count(rate_e r);
        case (r)
            RATE_SLOW: return CNT_SLOW;
            RATE_FAST: return CNT_FAST;
            default:   return CNT_NOM;
        endcase
    endfunction

    function automatic logic legal_count(byte_t c);
        return (c == CNT_SLOW) || (c == CNT_NOM) || (c == CNT_FAST);
    endfunction

    // largest legal count not above both the request and the bytes on hand
    function automatic byte_t fit_count(byte_t want, byte_t avail);
        if (avail >= want)          return want;
        else if (avail >= CNT_NOM)  return CNT_NOM;
        else if (avail >= CNT_SLOW) return CNT_SLOW;
        else                        return 8'd0;
    endfunction

endpackage

// File: rtl/framer_fifo.sv
module framer_fifo
    import framer_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  byte_t         din,
    input  logic          pop,
    output byte_t         dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    byte_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

endmodule

// File: rtl/rx_packer.sv
module rx_packer
    import framer_pkg::*;
#(
    parameter int LW    = 7,
    parameter int LO_TH = 24,
    parameter int HI_TH = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] fill,
    input  byte_t         fifo_dout,
    output logic          fifo_pop,
    output beat_t         beat,
    output logic          beat_valid,
    input  logic          beat_ready,
    output logic          udf_pulse
);

    logic  busy;
    pos_t  pos;
    byte_t cnt_q;
    rate_e rate;
    byte_t want, avail, fitted;
    logic  in_data;

    always_comb begin
        if (int'(fill) > HI_TH)      rate = RATE_FAST;
        else if (int'(fill) < LO_TH) rate = RATE_SLOW;
        else                         rate = RATE_NOM;
        want   = rate_count(rate);
        avail  = (int'(fill) > 255) ? 8'hFF : 8'(fill);
        fitted = fit_count(want, avail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            pos       <= '0;
            cnt_q     <= '0;
            udf_pulse <= 1'b0;
        end else begin
            udf_pulse <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    pos       <= '0;
                    cnt_q     <= fitted;
                    udf_pulse <= (fitted != want);
                end
            end else if (beat_ready) begin
                if (pos == LAST_POS) busy <= 1'b0;
                else                 pos  <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        in_data    = busy && (pos != '0) && ({2'b00, pos} <= cnt_q);
        beat_valid = busy;
        beat.sop   = busy && (pos == '0);
        if (pos == '0)   beat.data = cnt_q;
        else if (in_data) beat.data = fifo_dout;
        else             beat.data = PAD_BYTE;
        fifo_pop   = in_data && beat_ready;
    end

    a_r1_hold_stall: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat));

    a_r2_count_legal: assert property (@(posedge clk) disable iff (rst)
        busy |-> (legal_count(cnt_q) || cnt_q == 8'd0));

endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker
    import framer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t ep_data,
    input  logic  ep_valid,
    output logic  ep_ready,
    input  logic  fifo_full,
    output logic  push,
    output byte_t push_data,
    output logic  err_pulse
);

    pos_t  pos;
    byte_t cnt_q;
    logic  in_data, fire;

    always_comb begin
        in_data   = (pos != '0) && ({2'b00, pos} <= cnt_q);
        ep_ready  = !(in_data && fifo_full);
        fire      = ep_valid && ep_ready;
        push      = fire && in_data;
        push_data = ep_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            cnt_q     <= CNT_NOM;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (fire) begin
                pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
                if (pos == '0) begin
                    cnt_q     <= legal_count(ep_data) ? ep_data : CNT_NOM;
                    err_pulse <= !legal_count(ep_data);
                end
            end
        end
    end

    a_r7_push_room: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);

endmodule

// File: rtl/rate_framer.sv
module rate_framer
    import framer_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LO_TH = 24,
    parameter int HI_TH = 40,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic [7:0] ser_in_data,
    input  logic       ser_in_valid,
    output logic       ser_in_ready,
    output logic [7:0] ep_in_data,
    output logic       ep_in_valid,
    input  logic       ep_in_ready,
    output logic       ep_in_sop,
    input  logic [7:0] ep_out_data,
    input  logic       ep_out_valid,
    output logic       ep_out_ready,
    output logic [7:0] ser_out_data,
    output logic       ser_out_valid,
    input  logic       ser_out_ready,
    output logic       rx_overflow,
    output logic       rx_underflow,
    output logic       tx_underflow,
    output logic       count_err
);

    byte_t         rx_dout, tx_din, tx_dout;
    logic [LW-1:0] rx_level, tx_level;
    logic          rx_full, rx_empty, rx_pop;
    logic          tx_full, tx_empty, tx_push, tx_pop;
    logic          udf_pulse, err_pulse, tx_primed;
    beat_t         beat;

    framer_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(ser_in_valid), .din(ser_in_data),
        .pop(rx_pop), .dout(rx_dout),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    rx_packer #(.LW(LW), .LO_TH(LO_TH), .HI_TH(HI_TH)) u_packer (
        .clk(clk), .rst(rst), .start(frame_start),
        .fill(rx_level), .fifo_dout(rx_dout), .fifo_pop(rx_pop),
        .beat(beat), .beat_valid(ep_in_valid), .beat_ready(ep_in_ready),
        .udf_pulse(udf_pulse)
    );

    tx_unpacker u_unpacker (
        .clk(clk), .rst(rst),
        .ep_data(ep_out_data), .ep_valid(ep_out_valid), .ep_ready(ep_out_ready),
        .fifo_full(tx_full), .push(tx_push), .push_data(tx_din),
        .err_pulse(err_pulse)
    );

    framer_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_dout),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    assign ser_in_ready  = !rx_full;
    assign ep_in_data    = beat.data;
    assign ep_in_sop     = beat.sop;
    assign ser_out_data  = tx_dout;
    assign ser_out_valid = !tx_empty;
    assign tx_pop        = ser_out_ready && !tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
            tx_underflow <= 1'b0;
            count_err    <= 1'b0;
            tx_primed    <= 1'b0;
        end else begin
            if (ser_in_valid && rx_full)                 rx_overflow  <= 1'b1;
            if (udf_pulse)                               rx_underflow <= 1'b1;
            if (ser_out_ready && tx_empty && tx_primed)  tx_underflow <= 1'b1;
            if (err_pulse)                               count_err    <= 1'b1;
            if (tx_push)                                 tx_primed    <= 1'b1;
        end
    end

    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !rx_empty);

    a_r9_drop_flags: assert property (@(posedge clk) disable iff (rst)
        ser_in_valid && !ser_in_ready |=> rx_overflow);

    a_r4_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |=> rx_underflow);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        count_err |=> count_err);

endmodule

// File: tb/tb_rate_framer.sv
module tb_rate_framer;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start;
    logic [7:0] ser_in_data;
    logic       ser_in_valid;
    logic       ser_in_ready;
    logic [7:0] ep_in_data;
    logic       ep_in_valid;
    logic       ep_in_ready;
    logic       ep_in_sop;
    logic [7:0] ep_out_data;
    logic       ep_out_valid;
    logic       ep_out_ready;
    logic [7:0] ser_out_data;
    logic       ser_out_valid;
    logic       ser_out_ready;
    logic       rx_overflow, rx_underflow, tx_underflow, count_err;

    int vectors = 0;
    int miscompares = 0;

    rate_framer dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .ser_in_data(ser_in_data), .ser_in_valid(ser_in_valid), .ser_in_ready(ser_in_ready),
        .ep_in_data(ep_in_data), .ep_in_valid(ep_in_valid), .ep_in_ready(ep_in_ready),
        .ep_in_sop(ep_in_sop),
        .ep_out_data(ep_out_data), .ep_out_valid(ep_out_valid), .ep_out_ready(ep_out_ready),
        .ser_out_data(ser_out_data), .ser_out_valid(ser_out_valid), .ser_out_ready(ser_out_ready),
        .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
        .tx_underflow(tx_underflow), .count_err(count_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst          = 1'b1;
        frame_start  = 1'b0;
        ser_in_valid = 1'b0;
        ser_in_data  = 8'h00;
        ep_in_ready  = 1'b0;
        ep_out_valid = 1'b0;
        ep_out_data  = 8'h00;
        ser_out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    function automatic int want_of(int f);
        if (f > 40) return 36;
        if (f < 24) return 28;
        return 32;
    endfunction

    function automatic int fit_of(int w, int f);
        if (f >= w)  return w;
        if (f >= 32) return 32;
        if (f >= 28) return 28;
        return 0;
    endfunction

    task automatic run_rx(input int f);
        logic [7:0] got_d [0:36];
        logic       got_s [0:36];
        int got, k, w, e;
        do_reset();
        for (int i = 0; i < f; i++) begin
            @(negedge clk);
            ser_in_valid = 1'b1;
            ser_in_data  = 8'((f * 7 + i) & 255);
        end
        if (f == 64) begin
            @(negedge clk);
            ser_in_valid = 1'b1;
            ser_in_data  = 8'hEE;
            #1;
            chk(ser_in_ready == 1'b0, "R9 ready low when full", int'(ser_in_ready), 0);
        end
        @(negedge clk);
        ser_in_valid = 1'b0;
        chk(rx_overflow == (f == 64), "R9 overflow flag", int'(rx_overflow), int'(f == 64));
        chk(ep_in_valid == 1'b0, "R1 no packet before strobe", int'(ep_in_valid), 0);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        got = 0;
        k = 0;
        while (got < 37 && k < 2000) begin
            ep_in_ready = (f % 2 == 1) ? (k % 3 != 2) : 1'b1;
            frame_start = (f == 40 && got == 10);
            #1;
            if (ep_in_valid && ep_in_ready) begin
                got_d[got] = ep_in_data;
                got_s[got] = ep_in_sop;
                got++;
            end
            @(negedge clk);
            k++;
        end
        ep_in_ready = 1'b0;
        frame_start = 1'b0;
        chk(got == 37, "R1 packet length", got, 37);
        w = want_of(f);
        e = fit_of(w, f);
        for (int j = 0; j < got; j++) begin
            chk(got_s[j] == (j == 0), "R1 sop position", int'(got_s[j]), int'(j == 0));
            if (j == 0)
                chk(int'(got_d[0]) == e, "R2 R3 R4 count byte", int'(got_d[0]), e);
            else if (j <= e)
                chk(int'(got_d[j]) == ((f * 7 + j - 1) & 255), "R5 payload order",
                    int'(got_d[j]), (f * 7 + j - 1) & 255);
            else
                chk(got_d[j] == 8'h00, "R5 padding zero", int'(got_d[j]), 0);
        end
        chk(rx_underflow == (e != w), "R4 underflow flag", int'(rx_underflow), int'(e != w));
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            chk(ep_in_valid == 1'b0, "R6 no extra packet", int'(ep_in_valid), 0);
        end
    endtask

    task automatic run_tx();
        int raws [0:5];
        raws = '{32, 28, 36, 5, 37, 200};
        do_reset();
        for (int p = 0; p < 6; p++) begin
            int e, drained, g;
            e = (raws[p] == 28 || raws[p] == 32 || raws[p] == 36) ? raws[p] : 32;
            for (int j = 0; j < 37; j++) begin
                @(negedge clk);
                ep_out_valid = 1'b1;
                ep_out_data  = (j == 0) ? 8'(raws[p]) : (8'((p * 11 + j) & 255) ^ 8'h5A);
                #1;
                g = 0;
                while (!ep_out_ready && g < 100) begin
                    @(negedge clk);
                    #1;
                    g++;
                end
            end
            @(negedge clk);
            ep_out_valid = 1'b0;
            drained = 0;
            g = 0;
            while (g < 200) begin
                @(negedge clk);
                if (!ser_out_valid) begin
                    ser_out_ready = 1'b0;
                    break;
                end
                chk(ser_out_data == (8'(((p * 11 + drained + 1) & 255)) ^ 8'h5A),
                    "R7 forwarded byte", int'(ser_out_data),
                    int'(8'(((p * 11 + drained + 1) & 255)) ^ 8'h5A));
                ser_out_ready = 1'b1;
                drained++;
                g++;
            end
            ser_out_ready = 1'b0;
            chk(drained == e, "R7 R8 forwarded count", drained, e);
            chk(count_err == (p >= 3), "R8 count error flag", int'(count_err), int'(p >= 3));
            chk(tx_underflow == 1'b0, "R10 no underflow while paced", int'(tx_underflow), 0);
        end
        @(negedge clk);
        ser_out_ready = 1'b1;
        @(negedge clk);
        ser_out_ready = 1'b0;
        chk(tx_underflow == 1'b1, "R10 underflow on empty pull", int'(tx_underflow), 1);
        @(negedge clk);
        chk(tx_underflow == 1'b1, "R10 underflow sticky", int'(tx_underflow), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        chk(rx_overflow == 0 && rx_underflow == 0 && tx_underflow == 0 && count_err == 0,
            "R11 flags clear", int'({rx_overflow, rx_underflow, tx_underflow, count_err}), 0);
        chk(ep_in_valid == 0, "R11 ep_in_valid low", int'(ep_in_valid), 0);
        chk(ser_out_valid == 0, "R11 ser_out_valid low", int'(ser_out_valid), 0);
        chk(ser_in_ready == 1, "R11 ser_in_ready high", int'(ser_in_ready), 1);
        for (int f = 0; f <= 64; f++) run_rx(f);
        run_tx();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule